// File: doc/BRIEF.md
# Interleaved Burst-Correcting Memory ECC Codec

This block is a purely combinational encoder/decoder pair for 16-bit memory words. It is built to survive multi-bit upsets, where one particle strike flips several neighbouring cells. On the write side, the encoder splits the data word into two bytes. Each byte gets five check bits, giving a 13-bit sub-codeword. The two sub-codewords are then woven bit by bit into one 26-bit stored word.

On the read side, the decoder un-weaves the stored word and computes a 5-bit syndrome for each half. Each half then repairs one bit or two adjacent bits. Each sub-code corrects any single error and any burst of two adjacent bits. Because of the two-way interleave, any contiguous physical burst of up to four bits lands as at most two adjacent bits in each half, so it is repaired.

The decoder reports whether a repair was made and whether a half saw a syndrome it cannot explain. The surrounding memory controller decides what to do with those flags.

Top module: `ilv_ecc_top`

## Requirements
- R1: Stored bit 2*j+w holds bit j of sub-codeword w, for j in 0..12 and w in 0..1. Sub-codeword 0 carries data bits [7:0] and sub-codeword 1 carries data bits [15:8]. Within a sub-codeword, bits 0..7 are the data byte (LSB first) and bits 8..12 are check bits 0..4.
- R2: Check bit k of a sub-codeword is the XOR of the data bits i whose column h_i has bit k set. The columns h0..h7 are 0x16, 0x0B, 0x12, 0x0E, 0x07, 0x0A, 0x05, 0x1F. The check-bit columns h8..h12 are 0x01, 0x02, 0x04, 0x08, 0x10.
- R3: A word read back exactly as written returns the original data, with both dec_fixed_o and dec_fail_o low.
- R4: Any single flipped bit within either sub-codeword is repaired. The original data is returned, dec_fixed_o is high and dec_fail_o is low.
- R5: Any two adjacent flipped bits (j, j+1) within one sub-codeword are repaired, with dec_fixed_o high and dec_fail_o low.
- R6: Any contiguous run of 1 to 4 flipped stored bits, at any start position, is repaired with dec_fixed_o high and dec_fail_o low.
- R7: A half whose syndrome is nonzero but matches none of its 25 correctable patterns returns its received data byte unmodified and raises dec_fail_o.
- R8: dec_fixed_o is high when at least one half made a repair. dec_fail_o is high when at least one half was uncorrectable. A single half never reports both at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data_i | input | 16 | Data word to encode |
| enc_word_o | output | 26 | Interleaved stored word |
| dec_word_i | input | 26 | Stored word as read back |
| dec_data_o | output | 16 | Repaired (or passed-through) data |
| dec_fixed_o | output | 1 | At least one half was repaired |
| dec_fail_o | output | 1 | At least one half had an uncorrectable syndrome |

## Verification
The embedded assertions watch invariants that hold for any input:
- a half never flags repair and failure together;
- a zero syndrome raises no flag;
- at most two bits are ever flipped, and only when a repair is flagged;
- a failing half passes its data through;
- the encoder places data bits at the positions R1 gives.

Only the bench's scenarios can show that the chosen matrix really separates all 25 patterns, so that every injected single, adjacent pair and physical burst decodes to the original data. The same holds for the exact check-bit values and for deliberately unexplainable syndromes.

// File: rtl/ilv_ecc_pkg.sv
package ilv_ecc_pkg;

  localparam int SUB_DW = 8;
  localparam int SUB_CW = 5;
  localparam int SUB_NW = SUB_DW + SUB_CW;
  localparam int WAYS   = 2;
  localparam int WORD_DW = SUB_DW * WAYS;
  localparam int WORD_NW = SUB_NW * WAYS;

  // Column of the 5x13 check matrix for sub-codeword bit idx.
  // Data columns were picked so that all 13 columns and all 12
  // sums of neighbouring columns are distinct and nonzero.
  function automatic logic [SUB_CW-1:0] h_col(input int idx);
    logic [SUB_CW-1:0] col;
    case (idx)
      0:       col = 5'h16;
      1:       col = 5'h0B;
      2:       col = 5'h12;
      3:       col = 5'h0E;
      4:       col = 5'h07;
      5:       col = 5'h0A;
      6:       col = 5'h05;
      7:       col = 5'h1F;
      default: col = SUB_CW'(1) << (idx - SUB_DW);
    endcase
    return col;
  endfunction

  function automatic logic [SUB_CW-1:0] calc_chk(input logic [SUB_DW-1:0] d);
    logic [SUB_CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < SUB_DW; i++) begin
      if (d[i]) acc = acc ^ h_col(i);
    end
    return acc;
  endfunction

endpackage

// File: rtl/ilv_sub_enc.sv
module ilv_sub_enc
  import ilv_ecc_pkg::*;
(
  input  logic [SUB_DW-1:0] data_i,
  output logic [SUB_NW-1:0] cw_o
);

  logic [SUB_CW-1:0] chk;

  always_comb begin
    chk  = calc_chk(data_i);
    cw_o = {chk, data_i};
  end

endmodule

// File: rtl/ilv_sub_dec.sv
module ilv_sub_dec
  import ilv_ecc_pkg::*;
(
  input  logic [SUB_NW-1:0] cw_i,
  output logic [SUB_DW-1:0] data_o,
  output logic              fixed_o,
  output logic              fail_o
);

  localparam int NPAIR = SUB_NW - 1;

  logic [SUB_CW-1:0] syn;
  logic [SUB_NW-1:0] hit_one;
  logic [NPAIR-1:0]  hit_two;
  logic [SUB_NW-1:0] flip;

  always_comb begin
    syn = cw_i[SUB_NW-1:SUB_DW] ^ calc_chk(cw_i[SUB_DW-1:0]);
  end

  genvar gi;
  generate
    for (gi = 0; gi < SUB_NW; gi++) begin : g_one
      assign hit_one[gi] = (syn == h_col(gi));
    end
    for (gi = 0; gi < NPAIR; gi++) begin : g_two
      assign hit_two[gi] = (syn == (h_col(gi) ^ h_col(gi + 1)));
    end
  endgenerate

  always_comb begin
    flip = hit_one;
    for (int i = 0; i < NPAIR; i++) begin
      if (hit_two[i]) begin
        flip[i]     = 1'b1;
        flip[i + 1] = 1'b1;
      end
    end
  end

  always_comb begin
    data_o  = cw_i[SUB_DW-1:0] ^ flip[SUB_DW-1:0];
    fixed_o = (|hit_one) | (|hit_two);
    fail_o  = (syn != '0) && !fixed_o;
  end

  always_comb begin
    if (!$isunknown(cw_i)) begin
      a_r8_half_exclusive: assert (!(fixed_o && fail_o))
        else $error("half reports repair and failure together");
      a_r3_zero_syn_quiet: assert ((syn != '0) || (!fixed_o && !fail_o))
        else $error("flag raised on zero syndrome");
      a_r5_flip_bounded: assert (($countones(flip) <= 2) && ((flip != '0) == fixed_o))
        else $error("flip mask inconsistent with repair flag");
      a_r7_fail_passthru: assert (!fail_o || (data_o == cw_i[SUB_DW-1:0]))
        else $error("failing half altered its data");
    end
  end

endmodule

// File: rtl/ilv_ecc_top.sv
module ilv_ecc_top
  import ilv_ecc_pkg::*;
(
  input  logic [WORD_DW-1:0] enc_data_i,
  output logic [WORD_NW-1:0] enc_word_o,
  input  logic [WORD_NW-1:0] dec_word_i,
  output logic [WORD_DW-1:0] dec_data_o,
  output logic               dec_fixed_o,
  output logic               dec_fail_o
);

  logic [SUB_NW-1:0] enc_cw [WAYS];
  logic [SUB_NW-1:0] dec_cw [WAYS];
  logic [WAYS-1:0]   way_fixed;
  logic [WAYS-1:0]   way_fail;

  genvar gw, gj;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_way
      ilv_sub_enc u_enc (
        .data_i (enc_data_i[gw*SUB_DW +: SUB_DW]),
        .cw_o   (enc_cw[gw])
      );
      for (gj = 0; gj < SUB_NW; gj++) begin : g_bit
        assign enc_word_o[gj*WAYS + gw] = enc_cw[gw][gj];
        assign dec_cw[gw][gj]           = dec_word_i[gj*WAYS + gw];
      end
      ilv_sub_dec u_dec (
        .cw_i    (dec_cw[gw]),
        .data_o  (dec_data_o[gw*SUB_DW +: SUB_DW]),
        .fixed_o (way_fixed[gw]),
        .fail_o  (way_fail[gw])
      );
    end
  endgenerate

  always_comb begin
    dec_fixed_o = |way_fixed;
    dec_fail_o  = |way_fail;
  end

  always_comb begin
    if (!$isunknown(enc_data_i)) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int j = 0; j < SUB_DW; j++) begin
          a_r1_data_slot: assert (enc_word_o[j*WAYS + w] == enc_data_i[w*SUB_DW + j])
            else $error("data bit not at its stored slot");
        end
      end
    end
    if (!$isunknown(dec_word_i) && !dec_fixed_o && !dec_fail_o) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int j = 0; j < SUB_DW; j++) begin
          a_r3_clean_passthru: assert (dec_data_o[w*SUB_DW + j] == dec_word_i[j*WAYS + w])
            else $error("data changed without a repair flag");
        end
      end
    end
  end

endmodule

// File: tb/ilv_ecc_top_bench.sv
module ilv_ecc_top_bench;

  logic        clk;
  logic [15:0] enc_data_i;
  logic [25:0] enc_word_o;
  logic [25:0] dec_word_i;
  logic [15:0] dec_data_o;
  logic        dec_fixed_o;
  logic        dec_fail_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  ilv_ecc_top u_ilv_ecc_top (
    .enc_data_i  (enc_data_i),
    .enc_word_o  (enc_word_o),
    .dec_word_i  (dec_word_i),
    .dec_data_o  (dec_data_o),
    .dec_fixed_o (dec_fixed_o),
    .dec_fail_o  (dec_fail_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // R2 matrix columns, written from the requirement
  function automatic logic [4:0] col(input int i);
    logic [4:0] t [8] = '{5'h16, 5'h0B, 5'h12, 5'h0E, 5'h07, 5'h0A, 5'h05, 5'h1F};
    return t[i];
  endfunction

  function automatic logic [12:0] sub_word(input logic [7:0] d);
    logic [4:0] c = '0;
    for (int i = 0; i < 8; i++) if (d[i]) c ^= col(i);
    return {c, d};
  endfunction

  // R1 interleave
  function automatic logic [25:0] stored(input logic [15:0] d);
    logic [12:0] a = sub_word(d[7:0]);
    logic [12:0] b = sub_word(d[15:8]);
    logic [25:0] s;
    for (int j = 0; j < 13; j++) begin
      s[2*j]     = a[j];
      s[2*j + 1] = b[j];
    end
    return s;
  endfunction

  task automatic check_enc(input logic [15:0] d, input string tag);
    enc_data_i = d;
    #1;
    checks++;
    if (enc_word_o !== stored(d)) begin
      errors++;
      $display("FAIL %s encode: actual=%h expected=%h", tag, enc_word_o, stored(d));
    end
  endtask

  task automatic check_dec(input logic [25:0] w, input logic [15:0] ed,
                           input logic ef, input logic el, input string tag);
    dec_word_i = w;
    #1;
    checks++;
    if (dec_data_o !== ed || dec_fixed_o !== ef || dec_fail_o !== el) begin
      errors++;
      $display("FAIL %s: actual data=%h fixed=%b fail=%b expected data=%h fixed=%b fail=%b",
               tag, dec_data_o, dec_fixed_o, dec_fail_o, ed, ef, el);
    end
  endtask

  initial begin
    logic [15:0] d;
    logic [25:0] m;
    void'($urandom(32'h1C0DE5));
    enc_data_i = '0;
    dec_word_i = '0;
    #3;

    // R1 R2: directed and random encodings
    check_enc(16'h0000, "R1");
    check_enc(16'hFFFF, "R2");
    for (int i = 0; i < 16; i++) check_enc(16'h1 << i, "R2");
    for (int i = 0; i < 40; i++) check_enc(16'($urandom), "R1");

    // R3: clean words, including all-zero
    check_dec(stored(16'h0000), 16'h0000, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 20; i++) begin
      d = 16'($urandom);
      check_dec(stored(d), d, 1'b0, 1'b0, "R3");
    end

    // R4: every single error in each sub-codeword
    for (int w = 0; w < 2; w++)
      for (int j = 0; j < 13; j++) begin
        d = 16'($urandom);
        check_dec(stored(d) ^ (26'h1 << (2*j + w)), d, 1'b1, 1'b0, "R4");
      end

    // R5: every adjacent pair within each sub-codeword
    for (int w = 0; w < 2; w++)
      for (int j = 0; j < 12; j++) begin
        d = 16'($urandom);
        m = (26'h1 << (2*j + w)) | (26'h1 << (2*j + 2 + w));
        check_dec(stored(d) ^ m, d, 1'b1, 1'b0, "R5");
      end

    // R6: every contiguous physical burst of length 1..4
    for (int len = 1; len <= 4; len++)
      for (int s = 0; s <= 26 - len; s++) begin
        d = 16'($urandom);
        m = ((26'h1 << len) - 26'h1) << s;
        check_dec(stored(d) ^ m, d, 1'b1, 1'b0, "R6");
        check_dec(stored(~d) ^ m, ~d, 1'b1, 1'b0, "R6");
      end

    // R7: unexplainable syndrome 0x17 in half A (stored bits 0 and 16)
    d = 16'hA55A;
    check_dec(stored(d) ^ 26'h0010001, d ^ 16'h0001, 1'b0, 1'b1, "R7");
    // R7: same syndrome in half B (sub bits 4 and 12 -> stored 9 and 25)
    d = 16'h3C96;
    check_dec(stored(d) ^ ((26'h1 << 9) | (26'h1 << 25)), d ^ 16'h1000, 1'b0, 1'b1, "R7");

    // R8: half A uncorrectable while half B repairs a single error
    d = 16'h0F0F;
    check_dec(stored(d) ^ 26'h0010001 ^ 26'h2, d ^ 16'h0001, 1'b1, 1'b1, "R8");
    // R8: both halves repaired at once
    d = 16'h7E81;
    check_dec(stored(d) ^ 26'h0000F00, d, 1'b1, 1'b0, "R8");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule